// File: doc/BRIEF.md
# SMBus Target Transaction Sequencer

This block sits behind a byte-level I2C target front end. The front end has already handled bit timing, address matching and acknowledge generation. It reports bus events to this block as single-cycle pulses:

- a start that addresses the target for writing;
- a start that addresses it for reading;
- a stop;
- a master NACK after a read byte.

The front end also delivers each byte the master writes, with a valid strobe, and asks for a byte whenever the master reads one.

The sequencer turns this event stream into SMBus device operations:

- a quick-command pulse with a direction bit, when a transfer carries no data bytes;
- a write commit, which hands the collected bytes and their count to the device backend;
- a one-byte fetch from the backend for each read request.

Written bytes are collected in a buffer whose depth is a parameter. The first byte in the buffer is the command code. When a write phase is followed by a repeated start into a read, the bytes collected so far are committed at the repeated start, so the backend sees the command code before it serves the read. An event that arrives in an order SMBus does not allow sends the block into a sticky confused state. It stays there until the next stop, and every illegal event raises an error pulse.

Top module: `smb_txn_seq`

## Requirements
- R1: A synchronous active-high reset puts the block in idle with a byte count of zero. While reset is held and in the cycle after it, every output pulse (quick, commit, read-valid, error) is low.
- R2: A write-direction start moves idle to write-data. In any other state it moves the block to confused and raises the error pulse.
- R3: A read-direction start moves idle to read-data. In write-data with a nonzero count it issues a write commit and moves to read-data. In write-data with a zero count, and in every other state, it moves to confused and raises the error pulse.
- R4: A stop with a zero byte count, in write-data or read-data, issues a quick-command pulse. The direction bit is 1 from read-data and 0 from write-data.
- R5: A stop with a nonzero count issues a write commit in write-data, raises the error pulse without a commit in read-data, and does nothing further in idle, done or confused. Every stop returns the block to idle with a zero count, and a stop is the only way out of confused.
- R6: A master NACK moves read-data to done and leaves done as it is, with no error. In any other state it moves to confused and raises the error pulse.
- R7: A read request in read-data asserts the backend request output combinationally in the same cycle. One cycle later it returns the backend byte with a read-valid pulse, or 0xFF when the backend-present input is low. In any other state the request returns 0xFF with read-valid, moves the block to confused and raises the error pulse.
- R8: A written byte is appended to the buffer only in write-data. A byte that arrives when the buffer already holds DEPTH bytes is dropped and raises the error pulse. In any other state a byte is dropped and raises the error pulse, and the state does not change.
- R9: A commit presents the buffer on the commit data output, with byte i at bits [8i+7:8i] (byte 0 is the command code), together with the count. A commit made at a repeated start does not clear the count, so a later stop in read-data finds a nonzero count.
- R10: A written byte that arrives in the same cycle as a control event is applied first, and the control event then sees the updated count. When several control events coincide, only one acts, in the priority stop, read start, write start, NACK, read request.
- R11: The quick, commit, read-valid and error outputs are registered. Each is a single-cycle pulse on the clock edge that follows its triggering event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_start_wr | input | 1 | Start addressing the target for writing |
| ev_start_rd | input | 1 | Start addressing the target for reading |
| ev_stop | input | 1 | Stop condition |
| ev_nack | input | 1 | Master NACK after a read byte |
| wr_valid | input | 1 | A byte written by the master is present |
| wr_byte | input | 8 | The written byte |
| rd_req | input | 1 | The front end needs a byte for the master |
| be_present | input | 1 | A device backend is attached |
| be_data | input | 8 | Byte returned by the backend |
| be_req | output | 1 | Combinational request for one backend byte |
| rd_valid | output | 1 | Pulse: rd_byte holds the answer to a read request |
| rd_byte | output | 8 | Byte to send to the master |
| quick_pulse | output | 1 | Pulse: quick command detected |
| quick_dir | output | 1 | Quick command direction, 1 for read |
| commit_pulse | output | 1 | Pulse: write commit |
| commit_len | output | $clog2(DEPTH+1) | Number of committed bytes |
| commit_data | output | DEPTH*8 | Buffered bytes, byte 0 in the low bits |
| err_pulse | output | 1 | Pulse: illegal event or overflow |

## Verification
Two functions can fall in the same cycle: a byte is appended and a control event acts in that same cycle. The bench provokes this by raising the write strobe together with a stop, and again together with a read-direction start while the count is still zero. It judges the result by whether a commit appears with a length that includes the new byte and with that byte in the data, and with no error. A third case raises a stop together with a write start from idle and checks that only the stop acts.

// File: rtl/smb_txn_seq.sv
module smb_txn_seq #(
  parameter int DEPTH = 34,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_start_wr,
  input  logic             ev_start_rd,
  input  logic             ev_stop,
  input  logic             ev_nack,
  input  logic             wr_valid,
  input  logic [7:0]       wr_byte,
  input  logic             rd_req,
  input  logic             be_present,
  input  logic [7:0]       be_data,
  output logic             be_req,
  output logic             rd_valid,
  output logic [7:0]       rd_byte,
  output logic             quick_pulse,
  output logic             quick_dir,
  output logic             commit_pulse,
  output logic [CW-1:0]    commit_len,
  output logic [DEPTH*8-1:0] commit_data,
  output logic             err_pulse
);

  typedef enum logic [2:0] {ST_IDLE, ST_WR, ST_RD, ST_DONE, ST_CONF} st_t;

  st_t           state_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n, cnt_eff;
  logic [7:0]    buf_q [DEPTH];
  logic          append, q_n, dir_n, c_n, e_n, rv_n;
  logic [CW-1:0] len_n;
  logic [7:0]    rb_n;
  logic          other_ev;

  assign append   = wr_valid && state_q == ST_WR && cnt_q < CW'(DEPTH);
  assign cnt_eff  = cnt_q + CW'(append);
  assign other_ev = ev_stop || ev_start_rd || ev_start_wr || ev_nack;
  assign be_req   = rd_req && !other_ev && state_q == ST_RD;

  always_comb begin
    st_n  = state_q;
    cnt_n = cnt_eff;
    q_n   = 1'b0;
    dir_n = 1'b0;
    c_n   = 1'b0;
    len_n = commit_len;
    e_n   = wr_valid && !append;
    rv_n  = 1'b0;
    rb_n  = rd_byte;
    if (ev_stop) begin
      st_n  = ST_IDLE;
      cnt_n = '0;
      if (cnt_eff == '0) begin
        if (state_q == ST_WR || state_q == ST_RD) begin
          q_n   = 1'b1;
          dir_n = (state_q == ST_RD);
        end
      end else if (state_q == ST_WR) begin
        c_n   = 1'b1;
        len_n = cnt_eff;
      end else if (state_q == ST_RD) begin
        e_n = 1'b1;
      end
    end else if (ev_start_rd) begin
      if (state_q == ST_IDLE) begin
        st_n = ST_RD;
      end else if (state_q == ST_WR && cnt_eff != '0) begin
        c_n   = 1'b1;
        len_n = cnt_eff;
        st_n  = ST_RD;
      end else begin
        st_n = ST_CONF;
        e_n  = 1'b1;
      end
    end else if (ev_start_wr) begin
      if (state_q == ST_IDLE) begin
        st_n = ST_WR;
      end else begin
        st_n = ST_CONF;
        e_n  = 1'b1;
      end
    end else if (ev_nack) begin
      if (state_q == ST_RD || state_q == ST_DONE) begin
        st_n = ST_DONE;
      end else begin
        st_n = ST_CONF;
        e_n  = 1'b1;
      end
    end else if (rd_req) begin
      rv_n = 1'b1;
      if (state_q == ST_RD) begin
        rb_n = be_present ? be_data : 8'hFF;
      end else begin
        rb_n = 8'hFF;
        st_n = ST_CONF;
        e_n  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      cnt_q        <= '0;
      quick_pulse  <= 1'b0;
      quick_dir    <= 1'b0;
      commit_pulse <= 1'b0;
      commit_len   <= '0;
      err_pulse    <= 1'b0;
      rd_valid     <= 1'b0;
      rd_byte      <= 8'hFF;
    end else begin
      state_q      <= st_n;
      cnt_q        <= cnt_n;
      quick_pulse  <= q_n;
      quick_dir    <= dir_n;
      commit_pulse <= c_n;
      commit_len   <= len_n;
      err_pulse    <= e_n;
      rd_valid     <= rv_n;
      rd_byte      <= rb_n;
    end
  end

  always_ff @(posedge clk) begin
    if (append) buf_q[cnt_q[IW-1:0]] <= wr_byte;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_out
    assign commit_data[8*i +: 8] = buf_q[i];
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (state_q == ST_IDLE && cnt_q == '0 && !err_pulse && !commit_pulse));

  a_r5_stop_to_idle: assert property (@(posedge clk) disable iff (rst)
    ev_stop |=> (state_q == ST_IDLE && cnt_q == '0));

  a_r5_conf_sticky: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CONF && !ev_stop) |=> state_q == ST_CONF);

  a_r4_quick_after_stop: assert property (@(posedge clk) disable iff (rst)
    quick_pulse |-> (state_q == ST_IDLE && cnt_q == '0 && !commit_pulse));

  a_r9_commit_nonempty: assert property (@(posedge clk) disable iff (rst)
    commit_pulse |-> commit_len != '0);

  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH));

  a_r7_req_only_in_read: assert property (@(posedge clk) disable iff (rst)
    be_req |-> (state_q == ST_RD && rd_req));

endmodule

// File: tb/smb_txn_seq_tb.sv
module smb_txn_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 34;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 0, rst = 1;
  logic ev_start_wr = 0, ev_start_rd = 0, ev_stop = 0, ev_nack = 0;
  logic wr_valid = 0, rd_req = 0, be_present = 1;
  logic [7:0] wr_byte = 0, be_data = 8'h5A;
  logic be_req, rd_valid, quick_pulse, quick_dir, commit_pulse, err_pulse;
  logic [7:0] rd_byte;
  logic [CW-1:0] commit_len;
  logic [DEPTH*8-1:0] commit_data;

  int checks = 0, failures = 0;
  logic c_req;

  always #(CLK_PERIOD/2) clk = ~clk;

  smb_txn_seq #(.DEPTH(DEPTH)) u_dut (
    .clk, .rst, .ev_start_wr, .ev_start_rd, .ev_stop, .ev_nack,
    .wr_valid, .wr_byte, .rd_req, .be_present, .be_data,
    .be_req, .rd_valid, .rd_byte, .quick_pulse, .quick_dir,
    .commit_pulse, .commit_len, .commit_data, .err_pulse);

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive at a negedge, hold through one posedge, sample at the next negedge.
  task automatic step(input logic sw, input logic sr, input logic sp, input logic nk,
                      input logic wv, input logic [7:0] wb, input logic rq);
    ev_start_wr = sw; ev_start_rd = sr; ev_stop = sp; ev_nack = nk;
    wr_valid = wv; wr_byte = wb; rd_req = rq;
    #1 c_req = be_req;
    @(negedge clk);
    ev_start_wr = 0; ev_start_rd = 0; ev_stop = 0; ev_nack = 0;
    wr_valid = 0; rd_req = 0;
  endtask

  task automatic t_reset;
    rst = 1;
    repeat (2) @(negedge clk);
    check("R1 quick", quick_pulse, 0);
    check("R1 commit", commit_pulse, 0);
    check("R1 err", err_pulse, 0);
    rst = 0;
    @(negedge clk);
    check("R1 rd_valid after reset", rd_valid, 0);
  endtask

  task automatic t_quick;
    step(1,0,0,0,0,0,0);
    check("R2 start_wr idle no err", err_pulse, 0);
    ev_stop = 1; #1;
    check("R11 no pulse before edge", quick_pulse, 0);
    ev_stop = 0;
    step(0,0,1,0,0,0,0);
    check("R4 quick write", quick_pulse, 1);
    check("R4 dir write", quick_dir, 0);
    @(negedge clk);
    check("R11 quick single cycle", quick_pulse, 0);
    step(0,1,0,0,0,0,0);
    step(0,0,1,0,0,0,0);
    check("R4 quick read", quick_pulse, 1);
    check("R4 dir read", quick_dir, 1);
    check("R4 no err", err_pulse, 0);
  endtask

  task automatic t_write_commit;
    step(1,0,0,0,0,0,0);
    step(0,0,0,0,1,8'hA5,0);
    step(0,0,0,0,1,8'h01,0);
    step(0,0,0,0,1,8'h02,0);
    check("R8 append no err", err_pulse, 0);
    step(0,0,1,0,0,0,0);
    check("R5 commit on stop", commit_pulse, 1);
    check("R9 len", commit_len, 3);
    check("R9 byte0 command", commit_data[7:0], 8'hA5);
    check("R9 byte2", commit_data[23:16], 8'h02);
    check("R5 no quick", quick_pulse, 0);
  endtask

  task automatic t_repeated_start;
    step(1,0,0,0,0,0,0);
    step(0,0,0,0,1,8'h10,0);
    step(0,1,0,0,0,0,0);
    check("R3 commit on repeated start", commit_pulse, 1);
    check("R3 len", commit_len, 1);
    check("R3 no err", err_pulse, 0);
    be_present = 1; be_data = 8'h5A;
    step(0,0,0,0,0,0,1);
    check("R7 backend req", c_req, 1);
    check("R7 rd_valid", rd_valid, 1);
    check("R7 byte", rd_byte, 8'h5A);
    be_present = 0;
    step(0,0,0,0,0,0,1);
    check("R7 absent backend", rd_byte, 8'hFF);
    check("R7 absent no err", err_pulse, 0);
    be_present = 1;
    step(0,0,0,1,0,0,0);
    check("R6 nack read no err", err_pulse, 0);
    step(0,0,0,1,0,0,0);
    check("R6 nack done no err", err_pulse, 0);
    step(0,0,1,0,0,0,0);
    check("R5 stop done nothing", err_pulse | commit_pulse | quick_pulse, 0);
    // count kept after repeated-start commit: stop in read-data errors
    step(1,0,0,0,0,0,0);
    step(0,0,0,0,1,8'h20,0);
    step(0,1,0,0,0,0,0);
    step(0,0,1,0,0,0,0);
    check("R9 count kept -> stop err", err_pulse, 1);
    check("R5 read stop no commit", commit_pulse, 0);
  endtask

  task automatic t_confused;
    step(0,0,0,0,0,0,1);
    check("R7 req idle err", err_pulse, 1);
    check("R7 req idle FF", rd_byte, 8'hFF);
    check("R7 req idle valid", rd_valid, 1);
    step(1,0,0,0,0,0,0);
    check("R2 start_wr confused err", err_pulse, 1);
    step(0,0,0,1,0,0,0);
    check("R5 still confused nack err", err_pulse, 1);
    step(0,0,1,0,0,0,0);
    check("R5 stop from confused clean", err_pulse, 0);
    step(1,0,0,0,0,0,0);
    check("R2 after recovery", err_pulse, 0);
    step(1,0,0,0,0,0,0);
    check("R2 start_wr in write err", err_pulse, 1);
    step(0,0,1,0,0,0,0);
    step(1,0,0,0,0,0,0);
    step(0,1,0,0,0,0,0);
    check("R3 zero count read start err", err_pulse, 1);
    step(0,0,1,0,0,0,0);
    check("R5 stop confused no quick", quick_pulse, 0);
    step(0,0,0,1,0,0,0);
    check("R6 nack idle err", err_pulse, 1);
    step(0,0,1,0,0,0,0);
  endtask

  task automatic t_full;
    step(1,0,0,0,0,0,0);
    for (int i = 0; i < DEPTH; i++) step(0,0,0,0,1,8'(i + 1),0);
    check("R8 full no err", err_pulse, 0);
    step(0,0,0,0,1,8'hEE,0);
    check("R8 overflow err", err_pulse, 1);
    step(0,0,1,0,0,0,0);
    check("R8 len full", commit_len, DEPTH);
    check("R8 last byte kept", commit_data[8*(DEPTH-1) +: 8], DEPTH);
  endtask

  task automatic t_byte_in_read;
    step(0,1,0,0,0,0,0);
    step(0,0,0,0,1,8'h77,0);
    check("R8 byte in read err", err_pulse, 1);
    step(0,0,0,0,0,0,1);
    check("R8 state unchanged read ok", err_pulse, 0);
    check("R8 state unchanged byte", rd_byte, 8'h5A);
    step(0,0,0,1,0,0,0);
    step(0,0,1,0,0,0,0);
    check("R8 no commit from ignored byte", commit_pulse, 0);
  endtask

  task automatic t_same_cycle;
    step(1,0,0,0,0,0,0);
    step(0,0,1,0,1,8'h33,0);
    check("R10 byte+stop commit", commit_pulse, 1);
    check("R10 byte+stop len", commit_len, 1);
    check("R10 byte+stop data", commit_data[7:0], 8'h33);
    check("R10 byte+stop no quick", quick_pulse, 0);
    step(1,0,0,0,0,0,0);
    step(0,1,0,0,1,8'h44,0);
    check("R10 byte+rstart commit", commit_pulse, 1);
    check("R10 byte+rstart no err", err_pulse, 0);
    check("R10 byte+rstart data", commit_data[7:0], 8'h44);
    step(0,0,0,1,0,0,0);
    step(0,0,1,0,0,0,0);
    step(1,0,1,0,0,0,0);
    check("R10 stop beats start_wr", err_pulse, 0);
    step(0,0,0,0,1,8'h55,0);
    check("R10 still idle byte err", err_pulse, 1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_quick();
        t_write_commit();
        t_repeated_start();
        t_confused();
        t_full();
        t_byte_in_read();
        t_same_cycle();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule